// File: doc/BRIEF.md
# Last-Branch Record Ring

A small circular store that keeps the most recent taken control-flow transfers retired by a core. Each retired branch arrives on a one-cycle strobe. It carries a source address, a target address, a one-hot kind code, the privilege ring of its target and three status flags. A select value, loaded through a control write, can drop chosen kinds and privilege rings before anything is stored. Branches that pass the filter are written one per cycle into the slot after the top-of-stack pointer, and the pointer then advances to that slot.

Readback is combinational and runs newest first. Index 0 returns the entry at the top-of-stack pointer, index 1 returns the entry one before it, and so on modulo the depth. The three flags are packed into the top bits of the stored source word, and a sign-extended address is also supplied. Global enable, freeze on a performance-monitor interrupt, a one-cycle clear of all entries and a call-stack mode complete the block. In call-stack mode, calls push entries and near returns pop them, so the stored entries follow the live call chain.

Top module: `lbr_ring`

## Requirements
- R1: After reset the pointer is 0, the block is not frozen and every read index reports an entry that is not valid.
- R2: An accepted branch outside call-stack mode is written to slot (pointer+1) mod DEPTH, and the pointer moves to that slot. Read index i returns slot (pointer − i) AND (DEPTH−1). After DEPTH more writes, the oldest entry is overwritten.
- R3: Select bits 2..8 each suppress one kind when set. The kind input is one-hot, with bit 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump and 6 far, and it maps to select bit (kind bit + 2). A suppressed branch changes neither the pointer nor any entry.
- R4: Select bit 0 suppresses branches whose target is ring 0 (`br_tgt_ring0`=1). Select bit 1 suppresses branches whose target is above ring 0. Only the target ring is judged.
- R5: The stored source word is {mispred, in_tx, abort, source}, with mispred in bit ADDR_W−1. `rd_flags` returns {mispred, in_tx, abort}, and `rd_addr` is the source sign-extended from bit ADDR_W−4.
- R6: While enable is 0, no branch is recorded.
- R7: When freeze-on-interrupt is set and call-stack mode is off, a `pmi` pulse blocks the branch in the same cycle and sets the frozen state. While frozen, nothing is recorded. Only a control write releases the frozen state.
- R8: Select bit 9 is a positive enable for call-stack mode. In this mode a relative or indirect call pushes an entry, a near return moves the pointer back by one, other kinds are not recorded, and `pmi` never freezes.
- R9: A live count rises with every push, saturating at DEPTH, and falls with every pop. A pop at count 0 has no effect. In call-stack mode, read indices at or above the count report not valid.
- R10: `clear_all` zeroes every entry, the pointer and the count in one cycle. A branch in the same cycle is dropped.
- R11: An entry whose stored source word or target is zero reads as not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load control fields; releases freeze |
| ctl_enable | input | 1 | Global record enable |
| ctl_freeze_on_pmi | input | 1 | Freeze on interrupt request |
| ctl_select | input | 10 | Suppress bits 0..8, call-stack enable bit 9 |
| clear_all | input | 1 | Zero all entries and the pointer |
| pmi | input | 1 | Performance-monitor interrupt pulse |
| br_valid | input | 1 | Retired taken branch strobe |
| br_kind | input | 7 | One-hot branch kind |
| br_tgt_ring0 | input | 1 | Target runs at ring 0 |
| br_src | input | ADDR_W−3 | Source address |
| br_dst | input | ADDR_W | Target address |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch inside a transaction |
| br_abort | input | 1 | Transaction abort |
| rd_idx | input | log2(DEPTH) | Read position, 0 = newest |
| rd_valid | output | 1 | Entry at rd_idx is live and non-empty |
| rd_src | output | ADDR_W | Packed source word |
| rd_addr | output | ADDR_W | Sign-extended source address |
| rd_flags | output | 3 | {mispred, in_tx, abort} |
| rd_dst | output | ADDR_W | Target address |
| tos_o | output | log2(DEPTH) | Top-of-stack pointer |
| frozen_o | output | 1 | Freeze state |

## Verification
Clearing and recording can fall in the same cycle. The bench raises `clear_all` together with an accepted branch strobe and expects every position to read empty with the pointer at 0. The freeze logic and the recorder also collide: a `pmi` pulse that arrives with a branch must drop that branch when freeze is armed. In call-stack mode the same pair must record the branch and leave the block unfrozen. A 4-deep model in the bench predicts every read position after each step.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    localparam int KIND_W  = 7;
    localparam int SEL_W   = 10;
    localparam int FLAG_W  = 3;

    localparam int KB_RCALL = 1;
    localparam int KB_ICALL = 2;
    localparam int KB_NRET  = 3;

    localparam int SB_RING0  = 0;
    localparam int SB_RINGN  = 1;
    localparam int SB_KIND0  = 2;
    localparam int SB_CSTACK = 9;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } act_e;

    typedef struct packed {
        logic             en;
        logic             frz_en;
        logic [SEL_W-1:0] sel;
    } ctl_t;
endpackage

// File: rtl/lbr_filter.sv
module lbr_filter
    import lbr_pkg::*;
(
    input  ctl_t              ctl,
    input  logic              frozen,
    input  logic              pmi,
    input  logic              clear,
    input  logic              br_valid,
    input  logic [KIND_W-1:0] br_kind,
    input  logic              br_tgt_ring0,
    output act_e              act,
    output logic              freeze_req
);
    logic cs_mode;
    logic kind_drop;
    logic ring_drop;
    logic blocked;
    logic is_call;

    always_comb begin
        cs_mode    = ctl.sel[SB_CSTACK];
        freeze_req = pmi & ctl.frz_en & ~cs_mode;
        kind_drop  = |(br_kind & ctl.sel[SB_KIND0 +: KIND_W]);
        ring_drop  = br_tgt_ring0 ? ctl.sel[SB_RING0] : ctl.sel[SB_RINGN];
        blocked    = ~ctl.en | frozen | freeze_req | clear;
        is_call    = br_kind[KB_RCALL] | br_kind[KB_ICALL];
        act        = ACT_NONE;
        if (br_valid && !blocked && !kind_drop && !ring_drop) begin
            if (!cs_mode || is_call) begin
                act = ACT_PUSH;
            end else if (br_kind[KB_NRET]) begin
                act = ACT_POP;
            end
        end
    end
endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
    import lbr_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  ctl_t             ctl_new,
    input  act_e             act,
    input  logic             freeze_req,
    input  logic             clear,
    output ctl_t             ctl_cur,
    output logic             frozen,
    output logic [PTR_W-1:0] tos,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        ctl_t             ctl;
        logic             frozen;
        logic [PTR_W-1:0] tos;
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl    = ctl_new;
            st_d.frozen = 1'b0;
        end else if (freeze_req) begin
            st_d.frozen = 1'b1;
        end
        if (clear) begin
            st_d.tos = '0;
            st_d.cnt = '0;
        end else if (act == ACT_PUSH) begin
            st_d.tos = st_q.tos + PTR_W'(1);
            if (st_q.cnt != CNT_FULL) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (act == ACT_POP && st_q.cnt != '0) begin
            st_d.tos = st_q.tos - PTR_W'(1);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_cur = st_q.ctl;
    assign frozen  = st_q.frozen;
    assign tos     = st_q.tos;
    assign cnt     = st_q.cnt;
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
    parameter  int DEPTH  = 16,
    parameter  int ADDR_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [ADDR_W-1:0] wr_src,
    input  logic [ADDR_W-1:0] wr_dst,
    input  logic [PTR_W-1:0]  rd_slot,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] src;
        logic [DEPTH-1:0][ADDR_W-1:0] dst;
    } store_t;

    store_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clear) begin
            mem_d = '0;
        end else if (wr_en) begin
            mem_d.src[wr_slot] = wr_src;
            mem_d.dst[wr_slot] = wr_dst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_src = mem_q.src[rd_slot];
    assign rd_dst = mem_q.dst[rd_slot];
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
    import lbr_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int ADDR_W = 64,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int ABITS  = ADDR_W - FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_enable,
    input  logic              ctl_freeze_on_pmi,
    input  logic [SEL_W-1:0]  ctl_select,
    input  logic              clear_all,
    input  logic              pmi,
    input  logic              br_valid,
    input  logic [KIND_W-1:0] br_kind,
    input  logic              br_tgt_ring0,
    input  logic [ABITS-1:0]  br_src,
    input  logic [ADDR_W-1:0] br_dst,
    input  logic              br_mispred,
    input  logic              br_in_tx,
    input  logic              br_abort,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [FLAG_W-1:0] rd_flags,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [PTR_W-1:0]  tos_o,
    output logic              frozen_o
);
    ctl_t             ctl_new;
    ctl_t             ctl_cur;
    act_e             act;
    logic             freeze_req;
    logic             frozen;
    logic [PTR_W-1:0] tos;
    logic [CNT_W-1:0] cnt;
    logic [ADDR_W-1:0] packed_src;
    logic [PTR_W-1:0] rd_slot;
    logic             cs_mode;
    logic             live;

    assign ctl_new = '{en: ctl_enable, frz_en: ctl_freeze_on_pmi, sel: ctl_select};
    assign packed_src = {br_mispred, br_in_tx, br_abort, br_src};

    lbr_filter filt_i (
        .ctl          (ctl_cur),
        .frozen       (frozen),
        .pmi          (pmi),
        .clear        (clear_all),
        .br_valid     (br_valid),
        .br_kind      (br_kind),
        .br_tgt_ring0 (br_tgt_ring0),
        .act          (act),
        .freeze_req   (freeze_req)
    );

    lbr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_new    (ctl_new),
        .act        (act),
        .freeze_req (freeze_req),
        .clear      (clear_all),
        .ctl_cur    (ctl_cur),
        .frozen     (frozen),
        .tos        (tos),
        .cnt        (cnt)
    );

    lbr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_all),
        .wr_en   (act == ACT_PUSH),
        .wr_slot (tos + PTR_W'(1)),
        .wr_src  (packed_src),
        .wr_dst  (br_dst),
        .rd_slot (rd_slot),
        .rd_src  (rd_src),
        .rd_dst  (rd_dst)
    );

    always_comb begin
        rd_slot  = tos - rd_idx;
        cs_mode  = ctl_cur.sel[SB_CSTACK];
        live     = !cs_mode || ({1'b0, rd_idx} < cnt);
        rd_valid = live && (rd_src != '0) && (rd_dst != '0);
        rd_flags = rd_src[ADDR_W-1 -: FLAG_W];
        rd_addr  = {{FLAG_W{rd_src[ABITS-1]}}, rd_src[ABITS-1:0]};
    end

    assign tos_o    = tos;
    assign frozen_o = frozen;
endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk #(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_all,
    input logic             ctl_wr,
    input logic [1:0]       act,
    input logic [PTR_W-1:0] tos,
    input logic [CNT_W-1:0] cnt,
    input logic             frozen,
    input logic             en,
    input logic             cs_mode
);
    // R2: a push moves the pointer forward by one slot
    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd1 && !clear_all) |=> (tos == PTR_W'($past(tos) + PTR_W'(1))));

    // R6: disabled recorder leaves the pointer alone
    a_r6_disabled_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear_all) |=> $stable(tos));

    // R7: frozen state persists until a control write
    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ctl_wr) |=> frozen);

    // R7: nothing moves while frozen
    a_r7_frozen_still: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clear_all) |=> $stable(tos));

    // R8: call-stack mode never enters freeze
    a_r8_cs_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode && !frozen) |=> !frozen);

    // R9: pop on an empty stack is harmless
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd2 && cnt == '0 && !clear_all) |=> $stable(tos));

    // R9: live count never exceeds the depth
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R10: clear empties pointer and count
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (tos == '0 && cnt == '0));
endmodule

bind lbr_ring lbr_ring_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .ctl_wr    (ctl_wr),
    .act       (act),
    .tos       (tos),
    .cnt       (cnt),
    .frozen    (frozen),
    .en        (ctl_cur.en),
    .cs_mode   (ctl_cur.sel[9])
);

// File: tb/lbr_ring_tb.sv
module lbr_ring_tb_top;
    localparam int D  = 4;
    localparam int AW = 16;
    localparam int AB = AW - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_enable = 0, ctl_freeze_on_pmi = 0;
    logic [9:0] ctl_select = '0;
    logic clear_all = 0, pmi = 0, br_valid = 0, br_tgt_ring0 = 0;
    logic [6:0] br_kind = '0;
    logic [AB-1:0] br_src = '0;
    logic [AW-1:0] br_dst = '0;
    logic br_mispred = 0, br_in_tx = 0, br_abort = 0;
    logic [1:0] rd_idx = '0;
    logic rd_valid, frozen_o;
    logic [AW-1:0] rd_src, rd_addr, rd_dst;
    logic [2:0] rd_flags;
    logic [1:0] tos_o;

    always #4 clk = ~clk;

    lbr_ring #(.DEPTH(D), .ADDR_W(AW)) dut_i (.*);

    int n_total = 0, n_fail = 0;
    bit done = 0;

    logic [AW-1:0] m_src [D];
    logic [AW-1:0] m_dst [D];
    int m_tos = 0, m_cnt = 0;
    bit m_frozen = 0, m_en = 0, m_frz = 0;
    logic [9:0] m_sel = '0;
    int seq = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk(tos_o == 2'(m_tos), tag, "tos", tos_o, m_tos);
        chk(frozen_o == m_frozen, tag, "frozen", frozen_o, m_frozen);
        for (int i = 0; i < D; i++) begin
            automatic int p = (m_tos - i) & (D - 1);
            automatic bit ev = (m_src[p] != 0) && (m_dst[p] != 0) && (!m_sel[9] || i < m_cnt);
            rd_idx = 2'(i);
            #1;
            chk(rd_valid == ev, tag, "valid", rd_valid, ev);
            if (ev) begin
                chk(rd_src == m_src[p], tag, "src", rd_src, m_src[p]);
                chk(rd_dst == m_dst[p], tag, "dst", rd_dst, m_dst[p]);
                chk(rd_flags == m_src[p][AW-1 -: 3], tag, "flags", rd_flags, m_src[p][AW-1 -: 3]);
                chk(rd_addr == {{3{m_src[p][AB-1]}}, m_src[p][AB-1:0]}, tag, "addr",
                    rd_addr, {{3{m_src[p][AB-1]}}, m_src[p][AB-1:0]});
            end
        end
    endtask

    task automatic cfg(input bit en, input bit frz, input logic [9:0] sel);
        @(negedge clk);
        ctl_wr = 1; ctl_enable = en; ctl_freeze_on_pmi = frz; ctl_select = sel;
        @(posedge clk); #1;
        ctl_wr = 0;
        m_en = en; m_frz = frz; m_sel = sel; m_frozen = 0;
    endtask

    task automatic branch(input bit v, input logic [6:0] kind, input bit r0,
                          input logic [AB-1:0] s, input logic [AW-1:0] d,
                          input logic [2:0] fl, input bit pm, input bit clr);
        automatic bit fe = m_frz && !m_sel[9];
        automatic bit drop;
        @(negedge clk);
        br_valid = v; br_kind = kind; br_tgt_ring0 = r0; br_src = s; br_dst = d;
        {br_mispred, br_in_tx, br_abort} = fl; pmi = pm; clear_all = clr;
        @(posedge clk); #1;
        br_valid = 0; pmi = 0; clear_all = 0;
        drop = (|(kind & m_sel[8:2])) || (r0 ? m_sel[0] : m_sel[1]);
        if (clr) begin
            for (int i = 0; i < D; i++) begin m_src[i] = '0; m_dst[i] = '0; end
            m_tos = 0; m_cnt = 0;
        end else if (v && m_en && !m_frozen && !(pm && fe) && !drop) begin
            if (!m_sel[9] || kind[1] || kind[2]) begin
                m_tos = (m_tos + 1) & (D - 1);
                m_src[m_tos] = {fl, s};
                m_dst[m_tos] = d;
                if (m_cnt < D) m_cnt++;
            end else if (kind[3] && m_cnt > 0) begin
                m_tos = (m_tos - 1) & (D - 1);
                m_cnt--;
            end
        end
        if (pm && fe) m_frozen = 1;
    endtask

    task automatic rec(input logic [6:0] kind, input bit r0);
        seq++;
        branch(1, kind, r0, AB'(13'h0101 + seq * 37), AW'(16'h2000 + seq * 5),
               3'(seq), 0, 0);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin m_src[i] = '0; m_dst[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_all("R1");

        cfg(1, 0, 10'h000);
        for (int k = 0; k < 6; k++) begin
            rec(7'(1 << (k % 7)), k[0]);
            check_all("R2");
        end

        for (int k = 0; k < 7; k++) begin
            cfg(1, 0, 10'(1 << (k + 2)));
            rec(7'(1 << k), 0);
            check_all("R3");
            rec(7'(1 << ((k + 1) % 7)), 0);
            check_all("R3");
        end

        cfg(1, 0, 10'h001);
        rec(7'h01, 1); check_all("R4");
        rec(7'h01, 0); check_all("R4");
        cfg(1, 0, 10'h002);
        rec(7'h01, 0); check_all("R4");
        rec(7'h01, 1); check_all("R4");

        cfg(1, 0, 10'h000);
        for (int f = 0; f < 8; f++) begin
            branch(1, 7'h20, 0, AB'(f[0] ? 13'h1ABC : 13'h0ABC), 16'h3456, 3'(f), 0, 0);
            check_all("R5");
        end

        cfg(0, 0, 10'h000);
        rec(7'h01, 0); check_all("R6");

        cfg(1, 1, 10'h000);
        branch(1, 7'h01, 0, 13'h0111, 16'h0222, 3'd0, 1, 0); check_all("R7");
        rec(7'h01, 0); check_all("R7");
        cfg(1, 1, 10'h000);
        rec(7'h01, 0); check_all("R7");

        branch(1, 7'h01, 0, 13'h0333, 16'h0444, 3'd1, 0, 1); check_all("R10");

        cfg(1, 1, 10'h200);
        rec(7'h02, 0); rec(7'h04, 0); rec(7'h02, 0);
        check_all("R8");
        rec(7'h01, 0); check_all("R8");
        rec(7'h08, 0); check_all("R8");
        branch(1, 7'h02, 0, 13'h0555, 16'h0666, 3'd2, 1, 0); check_all("R8");
        for (int k = 0; k < 5; k++) begin
            rec(7'h08, 0);
            check_all("R9");
        end
        for (int k = 0; k < 6; k++) rec(7'h04, 0);
        check_all("R9");

        cfg(1, 0, 10'h000);
        branch(1, 7'h01, 0, 13'h0000, 16'h0777, 3'd0, 0, 0); check_all("R11");
        branch(1, 7'h01, 0, 13'h0123, 16'h0000, 3'd0, 0, 0); check_all("R11");

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule